// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the bus-facing half of a small serial EEPROM. It samples the two-wire clock (SCL) and data (SDA) lines with the system clock, finds start and stop conditions, and recognises its own device address. It then moves bytes between the bus and a 256 x 8 byte array. The block never drives SDA high. It only asserts an open-drain pull-down enable, which it uses for acknowledge bits and for zero bits of read data.

A write transfer carries one byte address and then any number of data bytes. The address is loaded into an internal byte pointer. Each data byte leaves on a write port together with the address it belongs to, and a commit pulse follows the closing stop. A separate programming controller collects the page, burns it into the array and raises a busy flag while it works. Reads come straight from the array's combinational read port. The pointer selects the byte, so current-address, random (dummy write followed by a repeated start) and sequential reads all share the same pointer.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the SDA pull-down is released, the pointer (rd_addr_o) is 0, and no write or commit pulse is issued.
- R2: The engine acknowledges an address byte only when its top four bits are 1010 and bits 3..1 equal strap_i. Bits are shifted MSB first. A byte that does not match gets no ACK, and the rest of that transfer produces no ACK and no write.
- R3: The engine acknowledges a byte by pulling SDA low during the ninth clock. The pull-down enable switches on only while SCL is low.
- R4: In a write transfer (R/W bit 0 = 0), the first byte after the address byte loads the pointer. Each later byte is acknowledged and appears once on wr_valid_o/wr_addr_o/wr_data_o.
- R5: After each data byte the low 4 bits of the pointer step by one and wrap within the 16-byte page, while the upper 4 bits stay the same. More than 16 bytes therefore overwrite the earliest ones.
- R6: A stop pulses commit_o only if the transfer passed at least one data byte. A stop after an address-only write gives no commit.
- R7: A read (R/W bit 0 = 1) returns the byte at the pointer, and each byte sent advances the pointer by one, with 255 followed by 0. After a read the pointer is one past the last byte sent.
- R8: A write transfer that carries only a byte address, followed by a repeated start with a read, returns data from that address.
- R9: In a read, a master ACK makes the engine send the next byte. A master NACK ends the output and leaves SDA released.
- R10: While prog_busy_i is high, the engine does not acknowledge its address byte.
- R11: A start in the middle of a transfer abandons it. A partly received byte is dropped, and the engine waits for a new address byte.
- R12: Read data is driven MSB first, and each bit is held through the SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 3 | Board-strapped low device address bits |
| prog_busy_i | input | 1 | Programming controller is burning a page |
| rd_addr_o | output | 8 | Byte pointer, array read address |
| rd_data_i | input | 8 | Array data at rd_addr_o |
| wr_valid_o | output | 1 | One-cycle pulse: a data byte was accepted |
| wr_addr_o | output | 8 | Address of the accepted byte |
| wr_data_o | output | 8 | Value of the accepted byte |
| commit_o | output | 1 | One-cycle pulse: stop closed a write with data |

## Verification
Suppose the byte pointer is corrupted. The next read returns the wrong byte within nine SCL periods of the read address byte, and wr_addr_o shows a wrong address on the next data byte. Suppose instead that the phase state is wrong (bit count or ACK slot off by one). Then an ACK is missing, or it lands in a data bit of the same byte, so the master's very next ACK sample shows it. Page wrap mistakes show on wr_addr_o at the seventeenth byte of a long write. A missing busy gate shows on the first poll after a stop, a few bus clocks later.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } tw_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_ADDR,
        K_DATA
    } tw_kind_e;

    localparam logic [3:0] DEV_TAG = 4'b1010;

endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    // synchronised line levels
    assign scl_o = smp_q.scl_sync[SYNC_STAGES-1];
    assign sda_o = smp_q.sda_sync[SYNC_STAGES-1];

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sync = {smp_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        smp_d.sda_sync = {smp_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        smp_d.scl_prev = scl_o;
        smp_d.sda_prev = sda_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) smp_q <= '1;
        else         smp_q <= smp_d;
    end

    // SDA moving while SCL stays high marks a frame boundary
    assign scl_rise_o = scl_o & ~smp_q.scl_prev;
    assign scl_fall_o = ~scl_o & smp_q.scl_prev;
    assign start_o    = scl_o & smp_q.scl_prev & smp_q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & smp_q.scl_prev & ~smp_q.sda_prev & sda_o;

endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
    import tw_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int STRAP_W = 3,
    parameter int PAGE_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic              prog_busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] rd_addr_o,
    output logic              sda_oe_o,
    output logic              wr_valid_o,
    output logic [DATA_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              commit_o
);

    localparam int ADDR_W = DATA_W;
    localparam int TAG_W  = DATA_W - STRAP_W - 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        tw_state_e         st;
        tw_kind_e          kind;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              rw;
        logic              mack;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              wrote;
        logic              wr_valid;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              commit;
    } eng_t;

    eng_t eng_d, eng_q;

    logic byte_done;
    logic dev_match;
    assign byte_done = scl_fall_i && (eng_q.cnt == CNT_FULL);
    assign dev_match = (eng_q.shreg[DATA_W-1 -: TAG_W] == DEV_TAG[TAG_W-1:0]) &&
                       (eng_q.shreg[STRAP_W:1] == strap_i) && !prog_busy_i;

    always_comb begin
        eng_d          = eng_q;
        eng_d.wr_valid = 1'b0;
        eng_d.commit   = 1'b0;
        if (start_i) begin
            eng_d.st    = ST_RX;
            eng_d.kind  = K_DEV;
            eng_d.cnt   = '0;
            eng_d.oe    = 1'b0;
            eng_d.wrote = 1'b0;
        end else if (stop_i) begin
            eng_d.st     = ST_IDLE;
            eng_d.oe     = 1'b0;
            eng_d.commit = eng_q.wrote;
            eng_d.wrote  = 1'b0;
        end else begin
            unique case (eng_q.st)
                ST_RX: begin
                    if (scl_rise_i) begin
                        eng_d.shreg = {eng_q.shreg[DATA_W-2:0], sda_i};
                        eng_d.cnt   = eng_q.cnt + 1'b1;
                    end else if (byte_done) begin
                        eng_d.cnt = '0;
                        eng_d.st  = ST_ACK;
                        eng_d.oe  = 1'b1;
                        unique case (eng_q.kind)
                            K_DEV: begin
                                eng_d.rw = eng_q.shreg[0];
                                if (!dev_match) begin
                                    eng_d.st = ST_IDLE;
                                    eng_d.oe = 1'b0;
                                end
                            end
                            K_ADDR: eng_d.ptr = eng_q.shreg[ADDR_W-1:0];
                            default: begin
                                eng_d.wr_valid = 1'b1;
                                eng_d.wr_addr  = eng_q.ptr;
                                eng_d.wr_data  = eng_q.shreg;
                                eng_d.wrote    = 1'b1;
                                eng_d.ptr      = {eng_q.ptr[ADDR_W-1:PAGE_W],
                                                  eng_q.ptr[PAGE_W-1:0] + 1'b1};
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        eng_d.oe  = 1'b0;
                        eng_d.cnt = '0;
                        if (eng_q.kind == K_DEV && eng_q.rw) begin
                            eng_d.st    = ST_TX;
                            eng_d.shreg = rd_data_i;
                            eng_d.oe    = ~rd_data_i[DATA_W-1];
                            eng_d.ptr   = eng_q.ptr + 1'b1;
                        end else begin
                            eng_d.st   = ST_RX;
                            eng_d.kind = (eng_q.kind == K_DEV) ? K_ADDR : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (eng_q.cnt == CNT_LAST) begin
                            eng_d.oe = 1'b0;
                            eng_d.st = ST_TXACK;
                        end else begin
                            eng_d.shreg = {eng_q.shreg[DATA_W-2:0], 1'b0};
                            eng_d.cnt   = eng_q.cnt + 1'b1;
                            eng_d.oe    = ~eng_q.shreg[DATA_W-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise_i) begin
                        eng_d.mack = ~sda_i;
                    end else if (scl_fall_i) begin
                        if (eng_q.mack) begin
                            eng_d.st    = ST_TX;
                            eng_d.cnt   = '0;
                            eng_d.shreg = rd_data_i;
                            eng_d.oe    = ~rd_data_i[DATA_W-1];
                            eng_d.ptr   = eng_q.ptr + 1'b1;
                        end else begin
                            eng_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) eng_q <= '0;
        else         eng_q <= eng_d;
    end

    assign rd_addr_o  = eng_q.ptr;
    assign sda_oe_o   = eng_q.oe;
    assign wr_valid_o = eng_q.wr_valid;
    assign wr_addr_o  = eng_q.wr_addr;
    assign wr_data_o  = eng_q.wr_data;
    assign commit_o   = eng_q.commit;

    // R3
    oe_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_oe_o) |-> !scl_i);

    // R10
    busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st == ST_RX && eng_q.kind == K_DEV && byte_done && prog_busy_i)
        |=> !sda_oe_o);

    // R11
    start_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (eng_q.st == ST_RX && eng_q.kind == K_DEV &&
                     eng_q.cnt == '0 && !sda_oe_o));

    // R5
    page_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> (rd_addr_o[ADDR_W-1:PAGE_W] == wr_addr_o[ADDR_W-1:PAGE_W]));

    // R9
    txack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st == ST_TXACK) |-> !sda_oe_o);

    // R6
    commit_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |-> $past(stop_i));

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
    parameter int DATA_W      = 8,
    parameter int STRAP_W     = 3,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               prog_busy_i,
    output logic [DATA_W-1:0]  rd_addr_o,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               wr_valid_o,
    output logic [DATA_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0]  wr_data_o,
    output logic               commit_o
);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    tw_line_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sampler (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    tw_byte_engine #(
        .DATA_W  (DATA_W),
        .STRAP_W (STRAP_W),
        .PAGE_W  (PAGE_W)
    ) i_engine (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_i       (scl_s),
        .sda_i       (sda_s),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (bus_start),
        .stop_i      (bus_stop),
        .strap_i     (strap_i),
        .prog_busy_i (prog_busy_i),
        .rd_data_i   (rd_data_i),
        .rd_addr_o   (rd_addr_o),
        .sda_oe_o    (sda_oe_o),
        .wr_valid_o  (wr_valid_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o),
        .commit_o    (commit_o)
    );

endmodule

// File: tb/test_tw_eeprom_slave.sv
module test_tw_eeprom_slave;

    localparam int Q    = 8;
    localparam int BUSY = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       busy;
    logic [7:0] rd_data;
    logic       sda_oe, wr_valid, commit;
    logic [7:0] wr_addr, wr_data, rd_addr;
    logic       sda_line;

    logic [7:0] mem     [256];
    logic [7:0] ref_img [256];
    logic [7:0] pend_d  [256];
    logic [255:0] pend_v;
    logic [7:0] log_a   [512];
    logic [7:0] log_d   [512];
    logic [7:0] wbuf    [32];
    int wr_n, commit_n, bcnt, glitch_n;
    logic oe_prev;
    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_ptr;

    localparam logic [7:0] DEV_W = {4'b1010, 3'b101, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, 3'b101, 1'b1};

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    tw_eeprom_slave i_tw_eeprom_slave (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (strap),
        .prog_busy_i (busy),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .commit_o    (commit)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [7:0] page_step(logic [7:0] a, int k);
        return {a[7:4], 4'(a[3:0] + k)};
    endfunction

    // array and programming-controller model, plus output monitors
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = init_val(i);
            pend_v = '0; busy = 1'b0; bcnt = 0; wr_n = 0; commit_n = 0;
            glitch_n = 0; oe_prev = 1'b0;
        end else begin
            if (sda_oe != oe_prev && scl_m) glitch_n++;
            oe_prev = sda_oe;
            if (wr_valid) begin
                pend_v[wr_addr] = 1'b1;
                pend_d[wr_addr] = wr_data;
                log_a[wr_n & 511] = wr_addr;
                log_d[wr_n & 511] = wr_data;
                wr_n++;
            end
            if (commit) begin
                commit_n++;
                for (int i = 0; i < 256; i++) if (pend_v[i]) mem[i] = pend_d[i];
                pend_v = '0; busy = 1'b1; bcnt = BUSY;
            end else if (bcnt != 0) begin
                bcnt--;
                if (bcnt == 0) busy = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
        end
        tick(1);
        sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic wait_ready();
        logic ack;
        for (int p = 0; p < 200; p++) begin
            bus_start(); send_byte(DEV_W, ack); bus_stop();
            if (ack) break;
        end
    endtask

    task automatic write_seq(input logic [7:0] a, input int n);
        logic ack;
        int log0, c0;
        log0 = wr_n; c0 = commit_n;
        bus_start();
        send_byte(DEV_W, ack);   chk("R2 R4 device ack on write", 32'(ack), 32'd1);
        send_byte(a, ack);       chk("R4 byte address ack", 32'(ack), 32'd1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk("R3 R4 data ack", 32'(ack), 32'd1);
        end
        bus_stop();
        for (int k = 0; k < n; k++) begin
            chk("R5 write address", 32'(log_a[(log0 + k) & 511]), 32'(page_step(a, k)));
            chk("R4 write data", 32'(log_d[(log0 + k) & 511]), 32'(wbuf[k]));
            ref_img[page_step(a, k)] = wbuf[k];
        end
        chk("R4 write count", 32'(wr_n - log0), 32'(n));
        chk("R6 commit count", 32'(commit_n - c0), (n > 0) ? 32'd1 : 32'd0);
        exp_ptr = (n > 0) ? page_step(a, n) : a;
        chk("R5 pointer after write", 32'(rd_addr), 32'(exp_ptr));
        if (n > 0) begin
            bus_start(); send_byte(DEV_W, ack); bus_stop();
            chk("R10 no ack while busy", 32'(ack), 32'd0);
            wait_ready();
        end
    endtask

    task automatic read_body(input int n);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            chk("R7 R9 R12 read data", 32'(b), 32'(ref_img[exp_ptr]));
            exp_ptr = exp_ptr + 8'd1;
        end
        chk("R9 released after nack", 32'(sda_oe), 32'd0);
        bus_stop();
        chk("R7 pointer after read", 32'(rd_addr), 32'(exp_ptr));
    endtask

    task automatic read_cur(input int n);
        logic ack;
        bus_start();
        send_byte(DEV_R, ack); chk("R7 device ack on read", 32'(ack), 32'd1);
        read_body(n);
    endtask

    task automatic read_rand(input logic [7:0] a, input int n);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack); chk("R8 dummy write ack", 32'(ack), 32'd1);
        send_byte(a, ack);     chk("R8 address ack", 32'(ack), 32'd1);
        bus_start();
        send_byte(DEV_R, ack); chk("R8 repeated start ack", 32'(ack), 32'd1);
        exp_ptr = a;
        read_body(n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic ack;
        int w0, c0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) ref_img[i] = init_val(i);
        exp_ptr = 8'd0;
        tick(5);
        chk("R1 sda released in reset", 32'(sda_oe), 32'd0);
        rst_n = 1'b1;
        tick(5);
        chk("R1 sda released", 32'(sda_oe), 32'd0);
        chk("R1 pointer zero", 32'(rd_addr), 32'd0);
        chk("R1 no write pulse", 32'(wr_n), 32'd0);
        chk("R1 no commit", 32'(commit_n), 32'd0);

        // R2: strap mismatch, then wrong fixed nibble
        w0 = wr_n; c0 = commit_n;
        bus_start();
        send_byte({4'b1010, 3'b001, 1'b0}, ack); chk("R2 strap mismatch nack", 32'(ack), 32'd0);
        send_byte(8'h20, ack);                   chk("R2 ignored byte nack", 32'(ack), 32'd0);
        send_byte(8'h55, ack);                   chk("R2 ignored data nack", 32'(ack), 32'd0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, 3'b101, 1'b0}, ack); chk("R2 tag mismatch nack", 32'(ack), 32'd0);
        bus_stop();
        chk("R2 no write", 32'(wr_n - w0), 32'd0);
        chk("R2 no commit", 32'(commit_n - c0), 32'd0);

        // R4 R6 R10: byte write then poll
        wbuf[0] = 8'hC5;
        write_seq(8'h10, 1);
        // R8 random read of it, R7 current read of the next
        read_rand(8'h10, 1);
        read_cur(1);

        // R6: address-only write gives no commit
        write_seq(8'h77, 0);
        read_cur(2);

        // R5: page wrap and overwrite
        for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'hA1 + k * 8'h11);
        write_seq(8'h3E, 4);
        read_rand(8'h30, 2);
        for (int k = 0; k < 18; k++) wbuf[k] = 8'(k * 8'h0D + 8'h40);
        write_seq(8'h82, 18);
        read_rand(8'h80, 16);

        // R7 R9: sequential read across the top of the array
        read_rand(8'hFD, 6);

        // R11: start abandons a partial data byte
        w0 = wr_n; c0 = commit_n;
        bus_start();
        send_byte(DEV_W, ack); chk("R11 device ack", 32'(ack), 32'd1);
        send_byte(8'h50, ack); chk("R11 address ack", 32'(ack), 32'd1);
        send_bits(8'h00, 3);
        bus_start();
        send_byte(DEV_R, ack); chk("R11 ack after restart", 32'(ack), 32'd1);
        exp_ptr = 8'h50;
        read_body(1);
        chk("R11 partial byte dropped", 32'(wr_n - w0), 32'd0);
        chk("R11 no commit", 32'(commit_n - c0), 32'd0);

        // constrained random mix
        for (int it = 0; it < 14; it++) begin
            int op, n;
            logic [7:0] a;
            op = int'($urandom % 3);
            a  = 8'($urandom);
            if (op == 0) begin
                n = 1 + int'($urandom % 18);
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                write_seq(a, n);
            end else if (op == 1) begin
                read_rand(a, 1 + int'($urandom % 6));
            end else begin
                read_cur(1 + int'($urandom % 4));
            end
        end

        chk("R3 sda enable only moves with scl low", 32'(glitch_n), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule